// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Controller

This block runs forty-eight open-drain general purpose pins, grouped as six ports of eight bits, behind a small synchronous register bus. Every pin has an output latch. Writing 0 to a latch bit pulls the pin low. Writing 1 lets the pin float high, so it can be read as an input. Every pin is passed through a synchronizer, and its changes are watched so that a rising edge, a falling edge, or both can be turned into a sticky status bit. A single active-low interrupt line is asserted while any status bit is set.

Software handles the interrupt through a per-bit arm register. Writing 0 to an arm bit clears that bit's status and keeps it from setting again. Writing 1 arms the bit once more. Edges that happened while a bit was disarmed are not remembered.

Addresses use a bank-and-index layout. The upper nibble selects the bank and the lower nibble selects the port. Pad drivers and pad sampling are modelled as a drive-low enable per bit and a sampled level per bit.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every output latch is 0xFF (no pad driven). All rising enables, falling enables, arm bits and status bits read 0x00, and irq_n is 1.
- R2: Port p latch is at address 0x00+p (p = 0..5), and bit b of port p is pin 8p+b. One cycle after a write, each bit written 0 sets pad_drive_lo high, and each bit written 1 sets it low.
- R3: A read of address 0x00+p returns the level of pins 8p..8p+7 sampled through a two-stage synchronizer, not the latch contents.
- R4: Rising enables are at 0x10+p and falling enables at 0x20+p, with 1 meaning enabled. An armed bit's status (0x40+p) sets within four cycles of a 0-to-1 pin change if its rising enable is 1, and of a 1-to-0 change if its falling enable is 1. With both enables set, either direction sets it. With neither set, nothing sets it.
- R5: Arm bits are at 0x30+p. Writing 0 to a bit clears its status and blocks further setting. Writing 1 re-arms it, and does not set status for edges seen while the bit was disarmed. If an edge and a clearing write land in the same cycle, the clear wins.
- R6: Status bits at 0x40+p stay set until cleared through the arm bank. Writes to the status addresses change nothing.
- R7: irq_n is 0 in the cycle after any status bit is 1, and 1 in the cycle after all status bits are 0.
- R8: A pin pulled low by its own latch produces the same edge events as one changed from outside.
- R9: Writes to undefined addresses (indices 6..15 in any bank, or banks 5..15) are ignored, and reads of them return 0x00.
- R10: Read data is registered. It reflects the address presented at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register address: bank in bits 7:4, port index in bits 3:0 |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Sampled pad levels, bit 8p+b for port p bit b |
| pad_drive_lo | output | 48 | Per-pin enable for pulling the pad low |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two things can fall in the same clock edge: a detected pin edge that would set a status bit, and a write to the arm bank that clears that same bit. The bench changes a pad at a known falling clock edge. It counts the synchronizer and history stages so that the clearing write is sampled on the very edge where the change is detected. It then requires the status bit to read 0, and requires irq_n to stay high on every cycle of the window, because a set-then-clear ordering would show up as a short pulse on irq_n.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register bank selected by the upper address nibble
  typedef enum logic [3:0] {
    BANK_PIN  = 4'h0,
    BANK_RISE = 4'h1,
    BANK_FALL = 4'h2,
    BANK_ARM  = 4'h3,
    BANK_STAT = 4'h4
  } bank_e;

  localparam int unsigned BANK_W     = 4;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned BANK_COUNT = 5;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] prv
);

  logic [WIDTH-1:0] chain [STAGES];

  // Pads idle high through their pull-ups, so reset the chain to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '1;
          else     chain[0] <= pad_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];

  // History register must always trail the synchronized level by one cycle
  AST_HISTORY_TRAILS: assert property (@(posedge clk) disable iff (rst)
    prv == $past(lvl)); // R4

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] wdata,
  input  logic              we_out,
  input  logic              we_rise,
  input  logic              we_fall,
  input  logic              we_arm,
  input  logic [PORT_W-1:0] lvl,
  input  logic [PORT_W-1:0] prv,
  output logic [PORT_W-1:0] drive_lo,
  output logic [PORT_W-1:0] rise_q,
  output logic [PORT_W-1:0] fall_q,
  output logic [PORT_W-1:0] arm_q,
  output logic [PORT_W-1:0] stat_q
);

  logic [PORT_W-1:0] out_q;
  logic [PORT_W-1:0] ev;
  logic [PORT_W-1:0] keep;
  logic [PORT_W-1:0] stat_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '1;
      rise_q <= '0;
      fall_q <= '0;
      arm_q  <= '0;
    end else begin
      if (we_out)  out_q  <= wdata;
      if (we_rise) rise_q <= wdata;
      if (we_fall) fall_q <= wdata;
      if (we_arm)  arm_q  <= wdata;
    end
  end

  assign drive_lo = ~out_q;

  // Qualified edge events; the arm value in force this cycle gates them.
  assign ev     = ((lvl & ~prv & rise_q) | (~lvl & prv & fall_q)) & arm_q;
  // A clearing write in the same cycle overrides a new event.
  assign keep   = we_arm ? wdata : '1;
  assign stat_n = (stat_q | ev) & keep;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_n;
  end

  AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(we_out) |-> drive_lo == ~$past(wdata)); // R2

  AST_NEED_EDGE: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~$past(stat_q) & ~($past(lvl) ^ $past(prv))) == '0); // R4

  AST_NO_SET_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~$past(stat_q) & ~$past(arm_q)) == '0); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(we_arm) |-> (stat_q & ~$past(wdata)) == '0); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((~stat_q & $past(stat_q)) != '0) |-> $past(we_arm)); // R6

endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_vec,
  input  logic [NUM_PORTS*PORT_W-1:0] rise_vec,
  input  logic [NUM_PORTS*PORT_W-1:0] fall_vec,
  input  logic [NUM_PORTS*PORT_W-1:0] arm_vec,
  input  logic [NUM_PORTS*PORT_W-1:0] stat_vec,
  output logic [PORT_W-1:0]           rdata
);

  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx;
  logic [PORT_W-1:0] pin_s, rise_s, fall_s, arm_s, stat_s;
  logic [PORT_W-1:0] rd_n;

  assign bank = addr[ADDR_W-1 -: BANK_W];
  assign idx  = addr[IDX_W-1:0];

  always_comb begin
    pin_s  = '0;
    rise_s = '0;
    fall_s = '0;
    arm_s  = '0;
    stat_s = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx == IDX_W'(p)) begin
        pin_s  = pin_vec [p*PORT_W +: PORT_W];
        rise_s = rise_vec[p*PORT_W +: PORT_W];
        fall_s = fall_vec[p*PORT_W +: PORT_W];
        arm_s  = arm_vec [p*PORT_W +: PORT_W];
        stat_s = stat_vec[p*PORT_W +: PORT_W];
      end
    end
    case (bank_e'(bank))
      BANK_PIN:  rd_n = pin_s;
      BANK_RISE: rd_n = rise_s;
      BANK_FALL: rd_n = fall_s;
      BANK_ARM:  rd_n = arm_s;
      BANK_STAT: rd_n = stat_s;
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bank) >= BANK_W'(BANK_COUNT)) |-> rdata == '0); // R9

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 6,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [PORT_W-1:0]           reg_wdata,
  input  logic                        reg_we,
  output logic [PORT_W-1:0]           reg_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_drive_lo,
  output logic                        irq_n
);

  localparam int unsigned PINS = NUM_PORTS * PORT_W;

  logic [PINS-1:0]   lvl, prv;
  logic [PINS-1:0]   rise_vec, fall_vec, arm_vec, stat_vec;
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx;

  assign bank = reg_addr[ADDR_W-1 -: BANK_W];
  assign idx  = reg_addr[IDX_W-1:0];

  gpio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_in (pad_in),
    .lvl    (lvl),
    .prv    (prv)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = reg_we && (idx == IDX_W'(p));

      gpio_irq_port #(.PORT_W(PORT_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .wdata    (reg_wdata),
        .we_out   (hit && bank == BANK_PIN),
        .we_rise  (hit && bank == BANK_RISE),
        .we_fall  (hit && bank == BANK_FALL),
        .we_arm   (hit && bank == BANK_ARM),
        .lvl      (lvl[p*PORT_W +: PORT_W]),
        .prv      (prv[p*PORT_W +: PORT_W]),
        .drive_lo (pad_drive_lo[p*PORT_W +: PORT_W]),
        .rise_q   (rise_vec[p*PORT_W +: PORT_W]),
        .fall_q   (fall_vec[p*PORT_W +: PORT_W]),
        .arm_q    (arm_vec[p*PORT_W +: PORT_W]),
        .stat_q   (stat_vec[p*PORT_W +: PORT_W])
      );
    end
  endgenerate

  gpio_irq_rdmux #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .pin_vec  (lvl),
    .rise_vec (rise_vec),
    .fall_vec (fall_vec),
    .arm_vec  (arm_vec),
    .stat_vec (stat_vec),
    .rdata    (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|stat_vec);
  end

  AST_IRQ_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    (|stat_vec) |=> !irq_n); // R7

  AST_IRQ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !(|stat_vec) |=> irq_n); // R7

endmodule

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic [47:0] ext = '1;
  logic [47:0] pad_in;
  logic [47:0] pad_drive_lo;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // Open-drain pad: pulled low by the block or by the outside world
  assign pad_in = ext & ~pad_drive_lo;

  gpio_edge_irq u_gpio_edge_irq (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_we       (reg_we),
    .reg_rdata    (reg_rdata),
    .pad_in       (pad_in),
    .pad_drive_lo (pad_drive_lo),
    .irq_n        (irq_n)
  );

  // {addr, wdata, expected readback}
  localparam logic [23:0] TBL [10] = '{
    {8'h10, 8'hA5, 8'hA5},
    {8'h15, 8'h3C, 8'h3C},
    {8'h20, 8'h5A, 8'h5A},
    {8'h25, 8'hC3, 8'hC3},
    {8'h33, 8'h0F, 8'h0F},
    {8'h06, 8'h77, 8'h00},
    {8'h16, 8'h77, 8'h00},
    {8'h50, 8'h12, 8'h00},
    {8'hFF, 8'h34, 8'h00},
    {8'h42, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ext = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a[3:0] > 4'd5 || a[7:4] > 4'd4) return "R9";
    case (a[7:4])
      4'h1, 4'h2: return "R4";
      4'h3:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int lows;
    do_reset();

    // R1 reset state
    chk("R1 drive", pad_drive_lo, 48'h0);
    chk("R1 irq_n", {47'h0, irq_n}, 48'h1);
    rd(8'h00, v); chk("R1 pins", {40'h0, v}, 48'hFF);
    rd(8'h12, v); chk("R1 rise", {40'h0, v}, 48'h0);
    rd(8'h24, v); chk("R1 fall", {40'h0, v}, 48'h0);
    rd(8'h31, v); chk("R1 arm",  {40'h0, v}, 48'h0);
    rd(8'h45, v); chk("R1 stat", {40'h0, v}, 48'h0);

    // Table walk: write then read back (R4 R5 R6 R9)
    foreach (TBL[i]) begin
      wr(TBL[i][23:16], TBL[i][15:8]);
      rd(TBL[i][23:16], v);
      chk(tag_of(TBL[i][23:16]), {40'h0, v}, {40'h0, TBL[i][7:0]});
    end

    // R10: read data follows the previous cycle's address
    @(negedge clk); reg_addr = 8'h10;
    @(negedge clk); reg_addr = 8'h20;
    chk("R10 first", {40'h0, reg_rdata}, 48'hA5);
    @(negedge clk);
    chk("R10 second", {40'h0, reg_rdata}, 48'h5A);

    // Reset again clears the table's settings (R1)
    do_reset();
    rd(8'h10, v); chk("R1 rise after re-reset", {40'h0, v}, 48'h0);

    // R2 R3 R8: self-driven falling edge on pin 8
    wr(8'h21, 8'h01);
    wr(8'h31, 8'hFF);
    wr(8'h01, 8'hFE);
    chk("R2 drive", pad_drive_lo, 48'h0000_0000_0100);
    settle();
    rd(8'h01, v); chk("R3 pins", {40'h0, v}, 48'hFE);
    rd(8'h41, v); chk("R8 stat", {40'h0, v}, 48'h01);
    chk("R7 irq low", {47'h0, irq_n}, 48'h0);

    // R5 clear, R7 release, re-arm keeps no memory, R4 rise disabled
    wr(8'h31, 8'hFE);
    @(negedge clk);
    chk("R7 irq high", {47'h0, irq_n}, 48'h1);
    rd(8'h41, v); chk("R5 cleared", {40'h0, v}, 48'h0);
    wr(8'h31, 8'hFF);
    wr(8'h01, 8'hFF);
    settle();
    rd(8'h41, v); chk("R4 rise disabled", {40'h0, v}, 48'h0);
    chk("R2 release", pad_drive_lo, 48'h0);

    // R4 rising only on pin 39
    wr(8'h14, 8'h80);
    wr(8'h34, 8'hFF);
    @(negedge clk); ext[39] = 1'b0;
    settle();
    rd(8'h44, v); chk("R4 fall ignored", {40'h0, v}, 48'h0);
    @(negedge clk); ext[39] = 1'b1;
    settle();
    rd(8'h44, v); chk("R4 rise sets", {40'h0, v}, 48'h80);
    wr(8'h34, 8'h7F);
    wr(8'h34, 8'hFF);

    // R4 both edges on pin 42, R6 status write ignored
    wr(8'h15, 8'h04);
    wr(8'h25, 8'h04);
    wr(8'h35, 8'hFF);
    @(negedge clk); ext[42] = 1'b0;
    settle();
    rd(8'h45, v); chk("R4 both fall", {40'h0, v}, 48'h04);
    wr(8'h45, 8'h00);
    rd(8'h45, v); chk("R6 write ignored", {40'h0, v}, 48'h04);
    wr(8'h35, 8'hFB);
    wr(8'h35, 8'hFF);
    @(negedge clk); ext[42] = 1'b1;
    settle();
    rd(8'h45, v); chk("R4 both rise", {40'h0, v}, 48'h04);
    wr(8'h35, 8'hFB);
    wr(8'h35, 8'hFF);

    // R5 disarmed bit ignores an edge, and re-arm recalls nothing
    wr(8'h10, 8'h01);
    wr(8'h30, 8'h00);
    @(negedge clk); ext[0] = 1'b0;
    settle();
    @(negedge clk); ext[0] = 1'b1;
    settle();
    rd(8'h40, v); chk("R5 disarmed", {40'h0, v}, 48'h0);
    wr(8'h30, 8'h01);
    settle();
    rd(8'h40, v); chk("R5 rearm no memory", {40'h0, v}, 48'h0);

    // R5 collision: falling edge on pin 19 meets a clearing write
    wr(8'h22, 8'h08);
    wr(8'h32, 8'hFF);
    settle();
    chk("R7 idle before collision", {47'h0, irq_n}, 48'h1);
    @(negedge clk); ext[19] = 1'b0;
    lows = 0;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 8'h32; reg_wdata = 8'hF7; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (!irq_n) lows++;
      @(negedge clk);
    end
    chk("R5 collision irq", lows, 0);
    rd(8'h42, v); chk("R5 collision stat", {40'h0, v}, 48'h0);
    wr(8'h32, 8'hFF);
    settle();
    rd(8'h42, v); chk("R5 collision rearm", {40'h0, v}, 48'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule